// File: doc/BRIEF.md
# NAND Flash Window Bridge

This block lets a processor drive an 8-bit raw NAND flash through plain memory accesses. Flash space is split into three write windows. The address of a write picks the kind of flash cycle: a plain data cycle, a command cycle with CLE high, or an address cycle with ALE high. A read anywhere in flash space is a data read strobed by RE#. A small register space holds the chip-enable control bits, the strobe timing counts and a synchronized copy of the ready/busy pin.

A processor access is a level request. The request is held until `busReady` pulses high for one cycle. A flash access keeps `busReady` low until the whole WE# or RE# cycle, including the hold phase, has completed. Chip enables are held by software. Each chip has an enable bit and an assert bit, and its active-low CE# output goes low only while both bits are set.

Top module: `nandWindowBridge`

## Requirements
- R1: A write in flash space with address bits 16 and 15 both clear is a data cycle. WE# goes low for the programmed low count, CLE and ALE stay low, and nandDq carries the write byte with nandDqOe high.
- R2: A flash-space write with bit 15 set and bit 16 clear is a command cycle. CLE is high through the WE# low phase and the hold phase.
- R3: A flash-space write with bit 16 set and bit 15 clear is an address cycle. ALE is high through the WE# low phase and the hold phase.
- R4: A flash-space write with bits 16 and 15 both set is rejected. No WE# or RE# strobe occurs, busErr is high in the single busReady cycle one clock after the request, and CLE and ALE are never high together.
- R5: A flash-space read is always a data read, whatever the window bits. RE# goes low for the low count, CLE and ALE stay low, and busRdata returns nandDqIn zero-extended.
- R6: Register 0x50 is read/write. For chip n, bit 2n is the enable and bit 2n+1 is the assert. nandCeN[n] is low exactly when both bits are set.
- R7: Bit 0 of register 0x58 is the ready/busy pin after a two-flop synchronizer, where 1 means ready. A change made one clock before a status read is not yet visible to that read.
- R8: Register 0x54 holds the strobe low count in bits [3:0] and the hold count in bits [7:4]. A count of 0 acts as 1. Both counts reset to 2.
- R9: A flash access raises busReady exactly low count + hold count + 1 clocks after the request. A register access raises it 1 clock after. busReady is high for one cycle.
- R10: In reset and right after it, all CE# outputs, WE# and RE# are high, CLE and ALE are low, and register 0x50 reads 0.
- R11: Only the low byte of a flash write reaches nandDq. Higher write-data bits are ignored.
- R12: Register offsets other than 0x50, 0x54 and 0x58 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busRegSel | input | 1 | 1 selects register space, 0 selects flash space |
| busWrite | input | 1 | Write request, held until busReady |
| busRead | input | 1 | Read request, held until busReady |
| busAddr | input | ADDR_W | Byte offset within the selected space |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid with busReady |
| busReady | output | 1 | One-cycle completion pulse |
| busErr | output | 1 | Rejected request, high with busReady |
| nandDq | output | 8 | Flash data bus out |
| nandDqOe | output | 1 | Flash data bus output enable |
| nandDqIn | input | 8 | Flash data bus in |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandCeN | output | NUM_CHIPS | Chip enables, active low |
| nandRb | input | 1 | Ready/busy pin, high means ready |

## Verification
The assertions check on every cycle the rules that hold no matter what traffic runs:
- CLE and ALE are never high together, and WE# and RE# are never low together.
- Data and latch lines stay stable while WE# is low.
- busReady is a single-cycle pulse, and a rejection shows only in a completion cycle with no strobe.
- CE# outputs are high during reset.

Only the bench scenarios can show the parts that depend on values:
- which window yields which latch signal, and the exact strobe and latency counts for each timing setting;
- the chip-enable bit pairing and the read data paths;
- the synchronizer delay, and that unmapped offsets and upper data bits have no effect.

// File: rtl/nandBridgePkg.sv
package nandBridgePkg;

  localparam int CMD_WIN_BIT = 15;
  localparam int ADR_WIN_BIT = 16;

  localparam logic [7:0] CTRL_OFS = 8'h50;
  localparam logic [7:0] TIME_OFS = 8'h54;
  localparam logic [7:0] STAT_OFS = 8'h58;

  typedef enum logic [2:0] {
    REQ_NONE,
    REQ_REG_WR,
    REQ_REG_RD,
    REQ_FL_WR,
    REQ_FL_RD,
    REQ_BAD
  } reqKindT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HOLD,
    ST_DONE
  } phaseT;

  typedef struct packed {
    logic latchReq;
    logic regWrite;
    logic weLow;
    logic reLow;
    logic busDrive;
    logic lineActive;
    logic capture;
  } strobeT;

endpackage

// File: rtl/nandSync2.sv
module nandSync2 (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;
endmodule

// File: rtl/nandBridgeCtrl.sv
module nandBridgeCtrl
  import nandBridgePkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busRegSel,
  input  logic             busWrite,
  input  logic             busRead,
  input  logic             winCmd,
  input  logic             winAdr,
  input  logic [CNT_W-1:0] lowCycles,
  input  logic [CNT_W-1:0] holdCycles,
  output strobeT           strobe,
  output logic             busReady,
  output logic             busErr
);
  phaseT            phase;
  reqKindT          reqKind;
  logic [CNT_W-1:0] cnt;
  logic             isRead;
  logic             badReq;
  logic [CNT_W-1:0] lowEff;
  logic [CNT_W-1:0] holdEff;

  assign lowEff  = (lowCycles  == '0) ? CNT_W'(1) : lowCycles;
  assign holdEff = (holdCycles == '0) ? CNT_W'(1) : holdCycles;

  always_comb begin
    reqKind = REQ_NONE;
    if (busWrite) begin
      if (busRegSel)             reqKind = REQ_REG_WR;
      else if (winCmd && winAdr) reqKind = REQ_BAD;
      else                       reqKind = REQ_FL_WR;
    end else if (busRead) begin
      reqKind = busRegSel ? REQ_REG_RD : REQ_FL_RD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= ST_IDLE;
      cnt    <= '0;
      isRead <= 1'b0;
      badReq <= 1'b0;
    end else begin
      unique case (phase)
        ST_IDLE: begin
          badReq <= 1'b0;
          unique case (reqKind)
            REQ_REG_WR, REQ_REG_RD: phase <= ST_DONE;
            REQ_BAD: begin
              phase  <= ST_DONE;
              badReq <= 1'b1;
            end
            REQ_FL_WR: begin
              phase  <= ST_LOW;
              isRead <= 1'b0;
              cnt    <= lowEff - CNT_W'(1);
            end
            REQ_FL_RD: begin
              phase  <= ST_LOW;
              isRead <= 1'b1;
              cnt    <= lowEff - CNT_W'(1);
            end
            default: phase <= ST_IDLE;
          endcase
        end
        ST_LOW: begin
          if (cnt == '0) begin
            phase <= ST_HOLD;
            cnt   <= holdEff - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (cnt == '0) phase <= ST_DONE;
          else           cnt   <= cnt - CNT_W'(1);
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.latchReq   = (phase == ST_IDLE) && (reqKind != REQ_NONE);
    strobe.regWrite   = (phase == ST_IDLE) && (reqKind == REQ_REG_WR);
    strobe.weLow      = (phase == ST_LOW) && !isRead;
    strobe.reLow      = (phase == ST_LOW) && isRead;
    strobe.busDrive   = ((phase == ST_LOW) || (phase == ST_HOLD)) && !isRead;
    strobe.lineActive = (phase == ST_LOW) || (phase == ST_HOLD);
    strobe.capture    = (phase == ST_LOW) && isRead && (cnt == '0);
  end

  assign busReady = (phase == ST_DONE);
  assign busErr   = (phase == ST_DONE) && badReq;
endmodule

// File: rtl/nandBridgeData.sv
module nandBridgeData
  import nandBridgePkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 32,
  parameter int NUM_CHIPS = 4,
  parameter int CNT_W     = 4,
  parameter int LOW_DEF   = 2,
  parameter int HOLD_DEF  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strobe,
  input  logic                 busRegSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [7:0]           nandDqIn,
  input  logic                 nandRb,
  output logic [DATA_W-1:0]    busRdata,
  output logic [7:0]           nandDq,
  output logic                 nandDqOe,
  output logic                 nandCle,
  output logic                 nandAle,
  output logic                 nandWeN,
  output logic                 nandReN,
  output logic [NUM_CHIPS-1:0] nandCeN,
  output logic [CNT_W-1:0]     lowCycles,
  output logic [CNT_W-1:0]     holdCycles
);
  localparam int CTRL_W = 2 * NUM_CHIPS;

  logic [CTRL_W-1:0] ctrlReg;
  logic [7:0]        byteReg;
  logic              cleReg;
  logic              aleReg;
  logic [DATA_W-1:0] rdataReg;
  logic [DATA_W-1:0] regRd;
  logic              rbSync;
  logic              hitCtrl;
  logic              hitTime;
  logic              hitStat;

  nandSync2 rbSyncInst (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(nandRb),
    .syncOut(rbSync)
  );

  assign hitCtrl = (busAddr == ADDR_W'(CTRL_OFS));
  assign hitTime = (busAddr == ADDR_W'(TIME_OFS));
  assign hitStat = (busAddr == ADDR_W'(STAT_OFS));

  always_comb begin
    regRd = '0;
    if (hitCtrl)      regRd = DATA_W'(ctrlReg);
    else if (hitTime) regRd = DATA_W'({holdCycles, lowCycles});
    else if (hitStat) regRd = DATA_W'(rbSync);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      lowCycles  <= CNT_W'(LOW_DEF);
      holdCycles <= CNT_W'(HOLD_DEF);
    end else if (strobe.regWrite) begin
      if (hitCtrl) ctrlReg <= busWdata[CTRL_W-1:0];
      if (hitTime) begin
        lowCycles  <= busWdata[CNT_W-1:0];
        holdCycles <= busWdata[2*CNT_W-1:CNT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg  <= '0;
      cleReg   <= 1'b0;
      aleReg   <= 1'b0;
      rdataReg <= '0;
    end else begin
      if (strobe.latchReq) begin
        byteReg <= busWdata[7:0];
        cleReg  <= busWrite && !busRegSel && busAddr[CMD_WIN_BIT] && !busAddr[ADR_WIN_BIT];
        aleReg  <= busWrite && !busRegSel && busAddr[ADR_WIN_BIT] && !busAddr[CMD_WIN_BIT];
        if (busRegSel && !busWrite) rdataReg <= regRd;
      end
      if (strobe.capture) rdataReg <= DATA_W'(nandDqIn);
    end
  end

  generate
    for (genvar chip = 0; chip < NUM_CHIPS; chip++) begin : gCe
      assign nandCeN[chip] = ~(ctrlReg[2*chip] & ctrlReg[2*chip+1]);
    end
  endgenerate

  assign busRdata = rdataReg;
  assign nandDq   = byteReg;
  assign nandDqOe = strobe.busDrive;
  assign nandCle  = cleReg && strobe.lineActive;
  assign nandAle  = aleReg && strobe.lineActive;
  assign nandWeN  = ~strobe.weLow;
  assign nandReN  = ~strobe.reLow;
endmodule

// File: rtl/nandWindowBridge.sv
module nandWindowBridge
  import nandBridgePkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 32,
  parameter int NUM_CHIPS = 4,
  parameter int CNT_W     = 4,
  parameter int LOW_DEF   = 2,
  parameter int HOLD_DEF  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busRegSel,
  input  logic                 busWrite,
  input  logic                 busRead,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busReady,
  output logic                 busErr,
  output logic [7:0]           nandDq,
  output logic                 nandDqOe,
  input  logic [7:0]           nandDqIn,
  output logic                 nandCle,
  output logic                 nandAle,
  output logic                 nandWeN,
  output logic                 nandReN,
  output logic [NUM_CHIPS-1:0] nandCeN,
  input  logic                 nandRb
);
  strobeT           strobe;
  logic [CNT_W-1:0] lowCycles;
  logic [CNT_W-1:0] holdCycles;

  nandBridgeCtrl #(.CNT_W(CNT_W)) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .busRegSel (busRegSel),
    .busWrite  (busWrite),
    .busRead   (busRead),
    .winCmd    (busAddr[CMD_WIN_BIT]),
    .winAdr    (busAddr[ADR_WIN_BIT]),
    .lowCycles (lowCycles),
    .holdCycles(holdCycles),
    .strobe    (strobe),
    .busReady  (busReady),
    .busErr    (busErr)
  );

  nandBridgeData #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_CHIPS(NUM_CHIPS),
    .CNT_W    (CNT_W),
    .LOW_DEF  (LOW_DEF),
    .HOLD_DEF (HOLD_DEF)
  ) dataInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busRegSel (busRegSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .nandDqIn  (nandDqIn),
    .nandRb    (nandRb),
    .busRdata  (busRdata),
    .nandDq    (nandDq),
    .nandDqOe  (nandDqOe),
    .nandCle   (nandCle),
    .nandAle   (nandAle),
    .nandWeN   (nandWeN),
    .nandReN   (nandReN),
    .nandCeN   (nandCeN),
    .lowCycles (lowCycles),
    .holdCycles(holdCycles)
  );
endmodule

// File: rtl/nandBridgeChecker.sv
module nandBridgeChecker #(
  parameter int NUM_CHIPS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busReady,
  input logic                 busErr,
  input logic [7:0]           nandDq,
  input logic                 nandCle,
  input logic                 nandAle,
  input logic                 nandWeN,
  input logic                 nandReN,
  input logic [NUM_CHIPS-1:0] nandCeN
);
  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle)); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN)); // R5

  AST_WE_LINES_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN && $past(!nandWeN)) |-> ($stable(nandDq) && $stable(nandCle) && $stable(nandAle))); // R1

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady); // R9

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busReady && nandWeN && nandReN)); // R4

  always @(negedge clk) begin
    if (!rstN) begin
      AST_CE_IN_RESET: assert (&nandCeN); // R10
    end
  end
endmodule

bind nandWindowBridge nandBridgeChecker #(.NUM_CHIPS(NUM_CHIPS)) chkInst (
  .clk     (clk),
  .rstN    (rstN),
  .busReady(busReady),
  .busErr  (busErr),
  .nandDq  (nandDq),
  .nandCle (nandCle),
  .nandAle (nandAle),
  .nandWeN (nandWeN),
  .nandReN (nandReN),
  .nandCeN (nandCeN)
);

// File: tb/nandWindowBridge_test.sv
module nandWindowBridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 32;
  localparam int NUM_CHIPS = 4;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 busRegSel = 1'b0;
  logic                 busWrite = 1'b0;
  logic                 busRead = 1'b0;
  logic [ADDR_W-1:0]    busAddr = '0;
  logic [DATA_W-1:0]    busWdata = '0;
  logic [DATA_W-1:0]    busRdata;
  logic                 busReady;
  logic                 busErr;
  logic [7:0]           nandDq;
  logic                 nandDqOe;
  logic [7:0]           nandDqIn = 8'h00;
  logic                 nandCle;
  logic                 nandAle;
  logic                 nandWeN;
  logic                 nandReN;
  logic [NUM_CHIPS-1:0] nandCeN;
  logic                 nandRb = 1'b1;

  int checks = 0;
  int errors = 0;

  int          aLat, aWe, aRe, aCle, aAle, aBoth, aOe;
  logic [7:0]  aDq;
  logic [31:0] aRdata;
  logic        aErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  nandWindowBridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CHIPS(NUM_CHIPS)) uut (
    .clk(clk), .rstN(rstN), .busRegSel(busRegSel), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .busErr(busErr), .nandDq(nandDq), .nandDqOe(nandDqOe), .nandDqIn(nandDqIn),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandCeN(nandCeN), .nandRb(nandRb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic regSel, input logic wr, input logic [ADDR_W-1:0] addr,
                        input logic [31:0] wdata);
    aLat = 0; aWe = 0; aRe = 0; aCle = 0; aAle = 0; aBoth = 0; aOe = 0;
    aDq = '0; aRdata = '0; aErr = 1'b0;
    @(negedge clk);
    busRegSel = regSel; busWrite = wr; busRead = !wr; busAddr = addr; busWdata = wdata;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      aLat++;
      if (!nandWeN) begin aWe++; aDq = nandDq; if (nandDqOe) aOe++; end
      if (!nandReN) aRe++;
      if (nandCle) aCle++;
      if (nandAle) aAle++;
      if (nandCle && nandAle) aBoth++;
      if (busReady) begin
        aRdata = busRdata; aErr = busErr;
        break;
      end
    end
    busWrite = 1'b0; busRead = 1'b0; busRegSel = 1'b0;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R10 ce in reset", 32'(nandCeN), 32'hF);
    check("R10 we/re in reset", {30'b0, nandWeN, nandReN}, 32'h3);
    check("R10 cle/ale in reset", {30'b0, nandCle, nandAle}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 ce after reset", 32'(nandCeN), 32'hF);
    access(1'b1, 1'b0, 17'h50, 0);
    check("R10 ctrl reg reset", aRdata, 32'h0);
    access(1'b1, 1'b0, 17'h54, 0);
    check("R8 timing default", aRdata, 32'h22);
    check("R9 register latency", aLat, 1);
  endtask

  task automatic testDataWrite();
    access(1'b0, 1'b1, 17'h00000, 32'hDEADBE5A);
    check("R1 we low cycles", aWe, 2);
    check("R1 dq byte", 32'(aDq), 32'h5A);
    check("R11 upper bits ignored", 32'(aDq), 32'h5A);
    check("R1 dq oe during we", aOe, 2);
    check("R1 no cle/ale", aCle + aAle, 0);
    check("R9 flash latency", aLat, 5);
    check("R1 no re", aRe, 0);
  endtask

  task automatic testCmdWrite();
    access(1'b0, 1'b1, 17'h08000, 32'h70);
    check("R2 cle cycles", aCle, 4);
    check("R2 no ale", aAle, 0);
    check("R2 cmd byte", 32'(aDq), 32'h70);
    check("R2 we low", aWe, 2);
  endtask

  task automatic testAddrWrite();
    access(1'b0, 1'b1, 17'h10000, 32'h1C3);
    check("R3 ale cycles", aAle, 4);
    check("R3 no cle", aCle, 0);
    check("R3 addr byte", 32'(aDq), 32'hC3);
  endtask

  task automatic testConflict();
    access(1'b0, 1'b1, 17'h18000, 32'hAA);
    check("R4 error flag", 32'(aErr), 1);
    check("R4 no strobe", aWe + aRe, 0);
    check("R4 no both lines", aBoth, 0);
    check("R4 latency", aLat, 1);
    access(1'b0, 1'b1, 17'h00000, 32'h11);
    check("R4 err clears", 32'(aErr), 0);
  endtask

  task automatic testRead();
    nandDqIn = 8'hB7;
    access(1'b0, 1'b0, 17'h08000, 0);
    check("R5 read data", aRdata, 32'hB7);
    check("R5 re low", aRe, 2);
    check("R5 no cle from window", aCle + aAle, 0);
    check("R5 no we", aWe, 0);
    check("R9 read latency", aLat, 5);
    nandDqIn = 8'h3E;
    access(1'b0, 1'b0, 17'h10000, 0);
    check("R5 read addr window", aRdata, 32'h3E);
  endtask

  task automatic testCtrlReg();
    access(1'b1, 1'b1, 17'h50, 32'h07);
    @(negedge clk);
    check("R6 ce pairing a", 32'(nandCeN), 32'hE);
    access(1'b1, 1'b0, 17'h50, 0);
    check("R6 readback", aRdata, 32'h07);
    access(1'b1, 1'b1, 17'h50, 32'hCC);
    @(negedge clk);
    check("R6 ce pairing b", 32'(nandCeN), 32'h5);
  endtask

  task automatic testStatus();
    nandRb = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b1, 1'b0, 17'h58, 0);
    check("R7 ready seen", aRdata, 32'h1);
    nandRb = 1'b0;
    access(1'b1, 1'b0, 17'h58, 0);
    check("R7 sync delay", aRdata, 32'h1);
    repeat (3) @(negedge clk);
    access(1'b1, 1'b0, 17'h58, 0);
    check("R7 busy seen", aRdata, 32'h0);
    nandRb = 1'b1;
  endtask

  task automatic testTiming();
    access(1'b1, 1'b1, 17'h54, 32'h31);
    access(1'b0, 1'b1, 17'h08000, 32'h90);
    check("R8 low 1", aWe, 1);
    check("R8 hold 3 cle", aCle, 4);
    check("R9 latency 1+3", aLat, 5);
    access(1'b1, 1'b1, 17'h54, 32'h00);
    access(1'b0, 1'b0, 17'h00000, 0);
    check("R8 zero as one", aRe, 1);
    check("R9 latency zero counts", aLat, 3);
    access(1'b1, 1'b1, 17'h54, 32'h24);
    access(1'b0, 1'b1, 17'h00000, 32'h01);
    check("R8 low 4", aWe, 4);
    check("R9 latency 4+2", aLat, 7);
  endtask

  task automatic testUnmapped();
    access(1'b1, 1'b1, 17'h5C, 32'hFFFF);
    access(1'b1, 1'b0, 17'h5C, 0);
    check("R12 unmapped reads zero", aRdata, 0);
    access(1'b1, 1'b0, 17'h50, 0);
    check("R12 ctrl untouched", aRdata, 32'hCC);
    access(1'b1, 1'b0, 17'h54, 0);
    check("R12 timing untouched", aRdata, 32'h24);
  endtask

  initial begin
    testReset();
    testDataWrite();
    testCmdWrite();
    testAddrWrite();
    testConflict();
    testRead();
    testCtrlReg();
    testStatus();
    testTiming();
    testUnmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule